// File: doc/BRIEF.md
# Vector Element Insert Unit

This unit writes one integer scalar (8, 32 or 64 bits wide) into a chosen lane of the low 128 bits of a 256-bit vector register image. The lane number comes from the low bits of an 8-bit immediate. Every other lane of the low half keeps the value of the vector being merged into.

Two encoding forms are supported. In the legacy form the merge base is the destination vector itself, and the upper 128 bits pass through unchanged. In the three-operand form the merge base is a second vector source and the upper 128 bits are cleared. The three-operand form also checks the vector-length bit and the operand-width bit against the 64-bit mode flag, and raises an illegal-opcode flag when the encoding is not allowed.

The result and the flag sit behind one register stage. That stage loads only when the input valid is high.

Top module: `vec_insert_unit`

## Requirements
- R1: A byte insert (elemSize = 0) writes scalarSrc[7:0] into result bits [8*k+7:8*k], where k = imm[3:0]. imm[7:4] has no effect.
- R2: A dword insert (elemSize = 1) writes scalarSrc[31:0] into result bits [32*k+31:32*k], where k = imm[1:0]. imm[7:2] has no effect.
- R3: A qword insert (elemSize = 2) writes scalarSrc[63:0] into lane imm[0]. Lane 0 is bits [63:0] and lane 1 is bits [127:64]. imm[7:1] has no effect.
- R4: Lanes of result[127:0] that are not selected take the value of destVec when threeOp = 0, and of mergeVec when threeOp = 1.
- R5: When threeOp = 0, result[255:128] equals destVec[255:128]. lBit, wBit and mode64 have no effect, and illegal stays 0.
- R6: When threeOp = 1 and the operation is legal, result[255:128] is zero.
- R7: When threeOp = 1 and lBit = 1, illegal becomes 1 and result keeps its previous value.
- R8: When threeOp = 1, elemSize = 2, wBit = 1 and mode64 = 0, illegal becomes 1 and result keeps its previous value. The same operation with mode64 = 1 is legal.
- R9: For a byte insert, wBit has no effect: with wBit = 1 the outcome is identical to wBit = 0, including when mode64 = 0.
- R10: elemSize = 3 is a reserved code. It sets illegal to 1 and leaves result unchanged.
- R11: outValid, result and illegal reflect the operation sampled at the previous rising clock edge on which inValid was high. outValid follows inValid with one cycle of delay. While inValid is low, result and illegal hold. An active-low reset clears outValid, illegal and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| inValid | input | 1 | Operation present this cycle |
| elemSize | input | 2 | 0 byte, 1 dword, 2 qword, 3 reserved |
| imm | input | 8 | Immediate holding the lane index |
| scalarSrc | input | 64 | Scalar value to insert |
| destVec | input | 256 | Destination image, merge base in legacy form |
| mergeVec | input | 256 | Second vector source, merge base in three-operand form |
| threeOp | input | 1 | 1 selects the three-operand form |
| mode64 | input | 1 | 64-bit mode active |
| wBit | input | 1 | Operand-width bit |
| lBit | input | 1 | Vector-length bit |
| outValid | output | 1 | Result stage holds a fresh operation |
| result | output | 256 | Registered merged vector |
| illegal | output | 1 | Registered illegal-opcode flag |

## Verification
The lane write and the illegal-opcode trap can both apply to the same operation. A three-operand insert with a valid lane index, but with lBit set or with a 64-bit operand outside 64-bit mode, must raise the flag and suppress the write. The bench provokes this by issuing a legal insert first and the illegal one straight after. It then judges that illegal is high and that result still holds the earlier merged value, not the one the lane write would have produced. The bench also issues both illegal causes together, and a byte insert with wBit set outside 64-bit mode, to show that only the qword width check reacts to wBit.

// File: rtl/vec_insert_pkg.sv
package vec_insert_pkg;
  localparam int LOW_BYTES = 16;

  typedef enum logic [1:0] {
    ELEM_BYTE  = 2'd0,
    ELEM_DWORD = 2'd1,
    ELEM_QWORD = 2'd2,
    ELEM_RSVD  = 2'd3
  } elem_size_e;

  typedef struct packed {
    logic                 capture;   // sample this cycle
    logic                 commit;    // load the result register
    logic                 trap;      // value for the illegal flag
    logic                 useMerge;  // base lanes from mergeVec
    logic                 zeroUpper; // clear bits above the low half
    elem_size_e           size;
    logic [LOW_BYTES-1:0] byteEn;    // byte lanes taking scalar data
  } ctrl_strobes_t;
endpackage

// File: rtl/vec_insert_ctrl.sv
module vec_insert_ctrl
  import vec_insert_pkg::*;
(
  input  logic          inValid,
  input  logic [1:0]    elemSize,
  input  logic [7:0]    imm,
  input  logic          threeOp,
  input  logic          mode64,
  input  logic          wBit,
  input  logic          lBit,
  output ctrl_strobes_t strobes
);
  elem_size_e size;
  logic       lengthFault;
  logic       widthFault;
  logic       rsvdFault;
  logic       anyFault;
  logic [LOW_BYTES-1:0] laneHit;

  assign size        = elem_size_e'(elemSize);
  assign lengthFault = threeOp && lBit;
  // wBit matters only for the qword width, so byte and dword inserts ignore it
  assign widthFault  = threeOp && (size == ELEM_QWORD) && wBit && !mode64;
  assign rsvdFault   = (size == ELEM_RSVD);
  assign anyFault    = lengthFault || widthFault || rsvdFault;

  always_comb begin
    for (int b = 0; b < LOW_BYTES; b++) begin
      unique case (size)
        ELEM_BYTE:  laneHit[b] = (4'(b)     == imm[3:0]);
        ELEM_DWORD: laneHit[b] = (2'(b / 4) == imm[1:0]);
        ELEM_QWORD: laneHit[b] = (1'(b / 8) == imm[0]);
        default:    laneHit[b] = 1'b0;
      endcase
    end
  end

  always_comb begin
    strobes.capture   = inValid;
    strobes.commit    = inValid && !anyFault;
    strobes.trap      = anyFault;
    strobes.useMerge  = threeOp;
    strobes.zeroUpper = threeOp;
    strobes.size      = size;
    strobes.byteEn    = laneHit;
  end
endmodule

// File: rtl/vec_insert_datapath.sv
module vec_insert_datapath
  import vec_insert_pkg::*;
#(
  parameter int VEC_W    = 256,
  parameter int LOW_W    = 128,
  parameter int SCALAR_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobes_t       strobes,
  input  logic [SCALAR_W-1:0] scalarSrc,
  input  logic [VEC_W-1:0]    destVec,
  input  logic [VEC_W-1:0]    mergeVec,
  output logic                outValid,
  output logic [VEC_W-1:0]    result,
  output logic                illegal
);
  localparam int UP_W   = VEC_W - LOW_W;
  localparam int NBYTES = LOW_W / 8;

  logic [LOW_W-1:0] lowNext;
  logic [UP_W-1:0]  upNext;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [7:0] srcByte;
    logic [7:0] baseByte;
    always_comb begin
      unique case (strobes.size)
        ELEM_BYTE:  srcByte = scalarSrc[7:0];
        ELEM_DWORD: srcByte = scalarSrc[8*(b%4) +: 8];
        default:    srcByte = scalarSrc[8*(b%8) +: 8];
      endcase
      baseByte = strobes.useMerge ? mergeVec[8*b +: 8] : destVec[8*b +: 8];
    end
    assign lowNext[8*b +: 8] = strobes.byteEn[b] ? srcByte : baseByte;
  end

  assign upNext = strobes.zeroUpper ? '0 : destVec[VEC_W-1:LOW_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      illegal  <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= strobes.capture;
      if (strobes.capture) illegal <= strobes.trap;
      if (strobes.commit)  result  <= {upNext, lowNext};
    end
  end
endmodule

// File: rtl/vec_insert_unit.sv
module vec_insert_unit
  import vec_insert_pkg::*;
#(
  parameter int VEC_W    = 256,
  parameter int LOW_W    = 128,
  parameter int SCALAR_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [1:0]          elemSize,
  input  logic [7:0]          imm,
  input  logic [SCALAR_W-1:0] scalarSrc,
  input  logic [VEC_W-1:0]    destVec,
  input  logic [VEC_W-1:0]    mergeVec,
  input  logic                threeOp,
  input  logic                mode64,
  input  logic                wBit,
  input  logic                lBit,
  output logic                outValid,
  output logic [VEC_W-1:0]    result,
  output logic                illegal
);
  ctrl_strobes_t strobes;

  vec_insert_ctrl ctrl_i (
    .inValid (inValid),
    .elemSize(elemSize),
    .imm     (imm),
    .threeOp (threeOp),
    .mode64  (mode64),
    .wBit    (wBit),
    .lBit    (lBit),
    .strobes (strobes)
  );

  vec_insert_datapath #(
    .VEC_W   (VEC_W),
    .LOW_W   (LOW_W),
    .SCALAR_W(SCALAR_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .scalarSrc(scalarSrc),
    .destVec  (destVec),
    .mergeVec (mergeVec),
    .outValid (outValid),
    .result   (result),
    .illegal  (illegal)
  );
endmodule

// File: rtl/vec_insert_checker.sv
module vec_insert_checker #(
  parameter int VEC_W = 256,
  parameter int LOW_W = 128
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [1:0]       elemSize,
  input logic [VEC_W-1:0] destVec,
  input logic             threeOp,
  input logic             mode64,
  input logic             wBit,
  input logic             lBit,
  input logic             outValid,
  input logic [VEC_W-1:0] result,
  input logic             illegal
);
  logic qwordWidthBad;
  assign qwordWidthBad = (elemSize == 2'd2) && wBit && !mode64;

  assert_valid_rise_R11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_fall_R11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(illegal)));
  assert_legacy_upper_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !threeOp && elemSize != 2'd3)
      |=> (!illegal && result[VEC_W-1:LOW_W] == $past(destVec[VEC_W-1:LOW_W])));
  assert_zero_upper_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && threeOp && !lBit && !qwordWidthBad && elemSize != 2'd3)
      |=> (result[VEC_W-1:LOW_W] == '0));
  assert_length_trap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && threeOp && lBit) |=> (illegal && $stable(result)));
  assert_width_trap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && threeOp && qwordWidthBad) |=> (illegal && $stable(result)));
  assert_byte_w_free_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && threeOp && elemSize == 2'd0 && !lBit) |=> !illegal);
  assert_rsvd_trap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && elemSize == 2'd3) |=> (illegal && $stable(result)));
endmodule

bind vec_insert_unit vec_insert_checker #(.VEC_W(VEC_W), .LOW_W(LOW_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .elemSize(elemSize),
  .destVec (destVec),
  .threeOp (threeOp),
  .mode64  (mode64),
  .wBit    (wBit),
  .lBit    (lBit),
  .outValid(outValid),
  .result  (result),
  .illegal (illegal)
);

// File: tb/vec_insert_unit_tb_top.sv
`timescale 1ns/1ps
module vec_insert_unit_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   elemSize = '0;
  logic [7:0]   imm = '0;
  logic [63:0]  scalarSrc = '0;
  logic [255:0] destVec = '0;
  logic [255:0] mergeVec = '0;
  logic         threeOp = 1'b0;
  logic         mode64 = 1'b0;
  logic         wBit = 1'b0;
  logic         lBit = 1'b0;
  logic         outValid;
  logic [255:0] result;
  logic         illegal;

  int checks = 0;
  int errors = 0;
  logic [255:0] expResult = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vec_insert_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .elemSize(elemSize), .imm(imm),
    .scalarSrc(scalarSrc), .destVec(destVec), .mergeVec(mergeVec), .threeOp(threeOp),
    .mode64(mode64), .wBit(wBit), .lBit(lBit), .outValid(outValid), .result(result),
    .illegal(illegal)
  );

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [255:0] model(input logic [1:0] sz, input logic [7:0] ix,
      input logic [63:0] sc, input logic [255:0] dv, input logic [255:0] mv, input logic three);
    logic [255:0] v;
    v = three ? {128'b0, mv[127:0]} : dv;
    case (sz)
      2'd0: v[8*ix[3:0] +: 8]  = sc[7:0];
      2'd1: v[32*ix[1:0] +: 32] = sc[31:0];
      2'd2: v[64*ix[0] +: 64]   = sc;
      default: v = dv;
    endcase
    return v;
  endfunction

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] sz, input logic [7:0] ix, input logic [63:0] sc,
      input logic [255:0] dv, input logic [255:0] mv, input logic three,
      input logic m64, input logic w, input logic l);
    @(negedge clk);
    elemSize = sz; imm = ix; scalarSrc = sc; destVec = dv; mergeVec = mv;
    threeOp = three; mode64 = m64; wBit = w; lBit = l; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic legalOp(input string tag, input logic [1:0] sz, input logic [7:0] ix,
      input logic three, input logic m64, input logic w);
    logic [63:0]  sc = {$urandom, $urandom};
    logic [255:0] dv = rnd256();
    logic [255:0] mv = rnd256();
    issue(sz, ix, sc, dv, mv, three, m64, w, 1'b0);
    expResult = model(sz, ix, sc, dv, mv, three);
    chk({tag, " result"}, result, expResult);
    chk({tag, " illegal"}, 256'(illegal), 256'(0));
    chk({tag, " outValid"}, 256'(outValid), 256'(1));
  endtask

  task automatic trapOp(input string tag, input logic [1:0] sz, input logic three,
      input logic m64, input logic w, input logic l);
    issue(sz, 8'h01, {$urandom, $urandom}, rnd256(), rnd256(), three, m64, w, l);
    chk({tag, " illegal"}, 256'(illegal), 256'(1));
    chk({tag, " result held"}, result, expResult);
  endtask

  task automatic testReset();
    chk("R11 reset outValid", 256'(outValid), 256'(0));
    chk("R11 reset illegal", 256'(illegal), 256'(0));
    chk("R11 reset result", result, 256'(0));
  endtask

  task automatic testByte();
    for (int k = 0; k < 16; k++)
      legalOp("R1 R4 R5 byte legacy", 2'd0, {4'(15 - k), 4'(k)}, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 16; k += 5)
      legalOp("R1 R4 R6 byte threeOp", 2'd0, {4'hA, 4'(k)}, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic testDword();
    for (int k = 0; k < 4; k++) begin
      legalOp("R2 R5 dword legacy", 2'd1, {6'h3F, 2'(k)}, 1'b0, 1'b1, 1'b0);
      legalOp("R2 R4 R6 dword threeOp", 2'd1, {6'h15, 2'(k)}, 1'b1, 1'b0, 1'b1);
    end
  endtask

  task automatic testQword();
    for (int k = 0; k < 2; k++) begin
      legalOp("R3 R5 qword legacy", 2'd2, {7'h7F, 1'(k)}, 1'b0, 1'b0, 1'b1);
      legalOp("R3 R6 R8 qword threeOp mode64", 2'd2, {7'h2A, 1'(k)}, 1'b1, 1'b1, 1'b1);
    end
  endtask

  task automatic testTraps();
    legalOp("R7 setup", 2'd1, 8'h02, 1'b1, 1'b1, 1'b0);
    trapOp("R7 lBit threeOp", 2'd1, 1'b1, 1'b1, 1'b0, 1'b1);
    legalOp("R8 setup", 2'd0, 8'h05, 1'b0, 1'b0, 1'b0);
    trapOp("R8 qword wBit outside mode64", 2'd2, 1'b1, 1'b0, 1'b1, 1'b0);
    trapOp("R7 R8 both causes", 2'd2, 1'b1, 1'b0, 1'b1, 1'b1);
    trapOp("R10 reserved size", 2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    legalOp("R5 legacy ignores lBit wBit", 2'd2, 8'h01, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testByteW();
    logic [63:0]  sc = {$urandom, $urandom};
    logic [255:0] dv = rnd256();
    logic [255:0] mv = rnd256();
    logic [255:0] withW;
    issue(2'd0, 8'h0B, sc, dv, mv, 1'b1, 1'b0, 1'b1, 1'b0);
    withW = result;
    chk("R9 byte wBit no trap", 256'(illegal), 256'(0));
    issue(2'd0, 8'h0B, sc, dv, mv, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R9 byte wBit same result", withW, result);
    expResult = model(2'd0, 8'h0B, sc, dv, mv, 1'b1);
    chk("R9 byte result value", result, expResult);
  endtask

  task automatic testIdle();
    legalOp("R11 setup", 2'd1, 8'h03, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    elemSize = 2'd0; imm = 8'h00; scalarSrc = '1; destVec = rnd256(); threeOp = 1'b1; lBit = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 idle outValid low", 256'(outValid), 256'(0));
    chk("R11 idle result held", result, expResult);
    chk("R11 idle illegal held", 256'(illegal), 256'(0));
    lBit = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testByte();
    testDword();
    testQword();
    testTraps();
    testByteW();
    testIdle();
    finishRun();
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end
endmodule